// File: doc/BRIEF.md
# Five-Source Two-Level Interrupt Controller

This block gathers interrupt requests from two external pins, two timer overflow events and a serial port. It picks one of them to present to a processor core as a vector request. Each source has its own enable bit and its own priority bit, and a global enable gates all of them. The winning source is reported as a three-bit index together with its priority level. The core accepts the request by pulsing an acknowledge. It ends a service routine by pulsing a return strobe.

Each source has a request flag that software can read, set and clear. An external pin either latches a rising edge into its flag or, in level mode, has its flag copy the pin. Timer flags are set by overflow pulses. The serial request is the OR of a receive flag and a transmit flag. On acceptance the controller clears the flag only where that is safe: edge-mode external flags and timer flags. Level-mode external flags and the two serial flags are left alone. A small tracker records which priority levels are in service. With it, a high-level request can interrupt a low-level routine, while requests at an equal or lower level wait for the return strobe.

Top module: `irq5_ctrl`

## Requirements
- R1: While reset is asserted and after its release, all six request flags read 0 and `vec_req` is 0.
- R2: The flag bits are [0] ext0, [1] tmr0, [2] ext1, [3] tmr1, [4] serial receive, [5] serial transmit. Source indices are 0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial. A source is pending when its flag is set (for serial: bit 4 or bit 5) and its `src_en` bit is 1. `vec_req` is raised with `vec_idx` naming an enabled pending source.
- R3: While `glb_en` is 0, `vec_req` stays 0 whatever is pending.
- R4: Among eligible sources at the same level, the lowest index wins.
- R5: A source whose `src_prio` bit is 1 is high level. It wins over any low-level source, and `vec_hi` reports the level of the source shown.
- R6: During a low-level routine only high-level sources may be vectored. During a high-level routine nothing is vectored until the return strobe.
- R7: In edge mode (`ext_edge_mode` bit = 1), a rising edge on an external pin sets its flag one cycle later. Acceptance of that source clears the flag.
- R8: In level mode, an external flag equals the pin value of the previous cycle. Acceptance does not clear it.
- R9: A `tmr_ovf` pulse sets the timer flag. Acceptance of that timer clears it.
- R10: `ser_rx_set` and `ser_tx_set` set flags 4 and 5. Acceptance of source 4 clears neither flag.
- R11: `sw_set` and `sw_clr` set or clear any flag one cycle later, and `sw_set` wins over `sw_clr`. A level-mode external flag keeps following its pin regardless.
- R12: `reti` ends the high-level routine if one is active, otherwise the low-level one. An acknowledge in the same cycle as `reti` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 5 | Per-source enable, indexed by source |
| src_prio | input | 5 | Per-source level, 1 = high |
| ext_pin | input | 2 | External request pins |
| ext_edge_mode | input | 2 | 1 = edge triggered, 0 = level triggered |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_rx_set | input | 1 | Serial receive-complete pulse |
| ser_tx_set | input | 1 | Serial transmit-complete pulse |
| sw_set | input | 6 | Software flag set strobes |
| sw_clr | input | 6 | Software flag clear strobes |
| vec_ack | input | 1 | Core accepts the current request |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_req | output | 1 | A source is ready to vector |
| vec_idx | output | 3 | Index of the selected source |
| vec_hi | output | 1 | Level of the selected source |
| irq_flags | output | 6 | Request flags |

## Verification
The assertions check four things on every cycle. A request never appears with the global enable off or for a disabled source. It always reports the level of its source, and it never shows a low source while a high one is pending. They also check the per-source flag rules at acceptance: timers clear, serial flags stay, and a level-mode flag follows its pin. Only the bench scenarios can show fixed-order selection under mixed patterns and the nesting of routines, where a high request preempts, a same-level request waits, and each return strobe unwinds one level. The same applies to an acknowledge being dropped when it coincides with a return strobe.

// File: rtl/irq5_pkg.sv
package irq5_pkg;
  localparam int NEXT  = 2;
  localparam int NTMR  = 2;
  localparam int NSRC  = NEXT + NTMR + 1;
  localparam int NFLAG = NSRC + 1;
  localparam int IDXW  = $clog2(NSRC);
  localparam int RX_BIT = 2 * NEXT;
  localparam int TX_BIT = RX_BIT + 1;
  localparam int SER_IDX = NSRC - 1;
endpackage

// File: rtl/irq5_flags.sv
module irq5_flags
  import irq5_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEXT-1:0]  ext_pin,
  input  logic [NEXT-1:0]  ext_edge_mode,
  input  logic [NTMR-1:0]  tmr_ovf,
  input  logic             rx_set,
  input  logic             tx_set,
  input  logic [NFLAG-1:0] sw_set,
  input  logic [NFLAG-1:0] sw_clr,
  input  logic             take,
  input  logic [IDXW-1:0]  take_idx,
  output logic [NFLAG-1:0] flags
);
  logic [NFLAG-1:0] flags_q, flags_d;
  logic [NEXT-1:0]  pin_q;
  logic [NEXT-1:0]  pin_rise;

  assign pin_rise = ext_pin & ~pin_q;

  always_comb begin
    flags_d = flags_q;
    for (int k = 0; k < NEXT; k++) begin
      if (take && take_idx == IDXW'(2 * k) && ext_edge_mode[k]) flags_d[2*k] = 1'b0;
      if (pin_rise[k])     flags_d[2*k] = 1'b1;
      if (sw_clr[2*k])     flags_d[2*k] = 1'b0;
      if (sw_set[2*k])     flags_d[2*k] = 1'b1;
      if (!ext_edge_mode[k]) flags_d[2*k] = ext_pin[k];
    end
    for (int k = 0; k < NTMR; k++) begin
      if (take && take_idx == IDXW'(2 * k + 1)) flags_d[2*k+1] = 1'b0;
      if (tmr_ovf[k])      flags_d[2*k+1] = 1'b1;
      if (sw_clr[2*k+1])   flags_d[2*k+1] = 1'b0;
      if (sw_set[2*k+1])   flags_d[2*k+1] = 1'b1;
    end
    if (rx_set)         flags_d[RX_BIT] = 1'b1;
    if (sw_clr[RX_BIT]) flags_d[RX_BIT] = 1'b0;
    if (sw_set[RX_BIT]) flags_d[RX_BIT] = 1'b1;
    if (tx_set)         flags_d[TX_BIT] = 1'b1;
    if (sw_clr[TX_BIT]) flags_d[TX_BIT] = 1'b0;
    if (sw_set[TX_BIT]) flags_d[TX_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pin_q   <= '0;
    end else begin
      flags_q <= flags_d;
      pin_q   <= ext_pin;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/irq5_arbiter.sv
module irq5_arbiter
  import irq5_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_prio,
  input  logic             glb_en,
  input  logic             in_hi,
  input  logic             in_lo,
  output logic             req,
  output logic [IDXW-1:0]  idx,
  output logic             hi
);
  logic [NSRC-1:0] pend, elig_hi, elig_lo;
  logic [IDXW-1:0] idx_hi, idx_lo;

  assign pend    = {flags[TX_BIT] | flags[RX_BIT], flags[2*NEXT-1:0]} & src_en & {NSRC{glb_en}};
  assign elig_hi = in_hi ? '0 : (pend & src_prio);
  assign elig_lo = (in_hi || in_lo) ? '0 : (pend & ~src_prio);

  always_comb begin
    idx_hi = '0;
    idx_lo = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_hi[i]) idx_hi = IDXW'(i);
      if (elig_lo[i]) idx_lo = IDXW'(i);
    end
  end

  assign hi  = |elig_hi;
  assign req = hi | (|elig_lo);
  assign idx = hi ? idx_hi : idx_lo;
endmodule

// File: rtl/irq5_level_track.sv
module irq5_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic in_hi,
  output logic in_lo
);
  logic hi_d, lo_d;

  always_comb begin
    hi_d = in_hi;
    lo_d = in_lo;
    if (reti) begin
      if (in_hi) hi_d = 1'b0;
      else       lo_d = 1'b0;
    end
    if (take) begin
      if (take_hi) hi_d = 1'b1;
      else         lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hi <= 1'b0;
      in_lo <= 1'b0;
    end else begin
      in_hi <= hi_d;
      in_lo <= lo_d;
    end
  end
endmodule

// File: rtl/irq5_ctrl.sv
module irq5_ctrl
  import irq5_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_prio,
  input  logic [NEXT-1:0]  ext_pin,
  input  logic [NEXT-1:0]  ext_edge_mode,
  input  logic [NTMR-1:0]  tmr_ovf,
  input  logic             ser_rx_set,
  input  logic             ser_tx_set,
  input  logic [NFLAG-1:0] sw_set,
  input  logic [NFLAG-1:0] sw_clr,
  input  logic             vec_ack,
  input  logic             reti,
  output logic             vec_req,
  output logic [IDXW-1:0]  vec_idx,
  output logic             vec_hi,
  output logic [NFLAG-1:0] irq_flags
);
  logic take, in_hi, in_lo;

  assign take = vec_ack & vec_req & ~reti;

  irq5_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_edge_mode(ext_edge_mode),
    .tmr_ovf(tmr_ovf), .rx_set(ser_rx_set), .tx_set(ser_tx_set),
    .sw_set(sw_set), .sw_clr(sw_clr), .take(take), .take_idx(vec_idx),
    .flags(irq_flags)
  );

  irq5_arbiter u_arb (
    .flags(irq_flags), .src_en(src_en), .src_prio(src_prio), .glb_en(glb_en),
    .in_hi(in_hi), .in_lo(in_lo), .req(vec_req), .idx(vec_idx), .hi(vec_hi)
  );

  irq5_level_track u_lvl (
    .clk(clk), .rst_n(rst_n), .take(take), .take_hi(vec_hi), .reti(reti),
    .in_hi(in_hi), .in_lo(in_lo)
  );
endmodule

// File: rtl/irq5_ctrl_chk.sv
module irq5_ctrl_chk
  import irq5_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic [NSRC-1:0]  src_en,
  input logic [NSRC-1:0]  src_prio,
  input logic [NEXT-1:0]  ext_pin,
  input logic [NEXT-1:0]  ext_edge_mode,
  input logic [NTMR-1:0]  tmr_ovf,
  input logic [NFLAG-1:0] sw_set,
  input logic [NFLAG-1:0] sw_clr,
  input logic             vec_ack,
  input logic             reti,
  input logic             vec_req,
  input logic [IDXW-1:0]  vec_idx,
  input logic             vec_hi,
  input logic [NFLAG-1:0] irq_flags
);
  logic [NSRC-1:0] live;
  logic            accepted;

  assign live     = {irq_flags[TX_BIT] | irq_flags[RX_BIT], irq_flags[2*NEXT-1:0]} & src_en;
  assign accepted = vec_req && vec_ack && !reti;

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (vec_idx < IDXW'(NSRC)));
  assert_src_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> live[vec_idx]);
  assert_glb_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> glb_en);
  assert_level_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (vec_hi == src_prio[vec_idx]));
  assert_high_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !vec_hi) |-> ((live & src_prio) == '0));
  assert_level_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_edge_mode[1] |=> (irq_flags[2] == $past(ext_pin[1])));
  assert_tmr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && vec_idx == IDXW'(1) && !tmr_ovf[0] && !sw_set[1]) |=> !irq_flags[1]);
  assert_ser_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && vec_idx == IDXW'(SER_IDX) && irq_flags[RX_BIT] && !sw_clr[RX_BIT])
      |=> irq_flags[RX_BIT]);
endmodule

bind irq5_ctrl irq5_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_en(src_en), .src_prio(src_prio),
  .ext_pin(ext_pin), .ext_edge_mode(ext_edge_mode), .tmr_ovf(tmr_ovf),
  .sw_set(sw_set), .sw_clr(sw_clr), .vec_ack(vec_ack), .reti(reti),
  .vec_req(vec_req), .vec_idx(vec_idx), .vec_hi(vec_hi), .irq_flags(irq_flags)
);

// File: tb/irq5_ctrl_tb.sv
module irq5_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       glb_en;
  logic [4:0] src_en, src_prio;
  logic [1:0] ext_pin, ext_edge_mode, tmr_ovf;
  logic       ser_rx_set, ser_tx_set;
  logic [5:0] sw_set, sw_clr;
  logic       vec_ack, reti;
  logic       vec_req, vec_hi;
  logic [2:0] vec_idx;
  logic [5:0] irq_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq5_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_en(src_en), .src_prio(src_prio),
    .ext_pin(ext_pin), .ext_edge_mode(ext_edge_mode), .tmr_ovf(tmr_ovf),
    .ser_rx_set(ser_rx_set), .ser_tx_set(ser_tx_set), .sw_set(sw_set), .sw_clr(sw_clr),
    .vec_ack(vec_ack), .reti(reti), .vec_req(vec_req), .vec_idx(vec_idx),
    .vec_hi(vec_hi), .irq_flags(irq_flags)
  );

  // {glb, en[4:0], prio[4:0], set[5:0], exp_req, exp_idx[2:0]}
  localparam logic [20:0] VECS [8] = '{
    {1'b1, 5'b11111, 5'b00000, 6'b001111, 1'b1, 3'd0},  // R2 R4
    {1'b1, 5'b11111, 5'b00000, 6'b001110, 1'b1, 3'd1},  // R4
    {1'b1, 5'b11111, 5'b00000, 6'b110000, 1'b1, 3'd4},  // R2 serial
    {1'b0, 5'b11111, 5'b00000, 6'b111111, 1'b0, 3'd0},  // R3
    {1'b1, 5'b11110, 5'b00000, 6'b000011, 1'b1, 3'd1},  // R2 disabled src
    {1'b1, 5'b11111, 5'b10000, 6'b111111, 1'b1, 3'd4},  // R5
    {1'b1, 5'b11111, 5'b01000, 6'b001010, 1'b1, 3'd3},  // R5
    {1'b1, 5'b11111, 5'b00000, 6'b000000, 1'b0, 3'd0}   // R2 nothing pending
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    sw_set = '0; sw_clr = '0; tmr_ovf = '0;
    ser_rx_set = 1'b0; ser_tx_set = 1'b0; vec_ack = 1'b0; reti = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; glb_en = 1'b1; src_en = '1; src_prio = '0;
    ext_pin = '0; ext_edge_mode = 2'b11; tmr_ovf = '0;
    ser_rx_set = 1'b0; ser_tx_set = 1'b0; sw_set = '0; sw_clr = '0;
    vec_ack = 1'b0; reti = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 flags in reset", 8'(irq_flags), 8'h00);
    check("R1 req in reset", 8'(vec_req), 8'h0);
    rst_n = 1'b1;
    step();
    check("R1 flags after reset", 8'(irq_flags), 8'h00);
    check("R1 req after reset", 8'(vec_req), 8'h0);

    for (int i = 0; i < 8; i++) begin
      glb_en = VECS[i][20]; src_en = VECS[i][19:15]; src_prio = VECS[i][14:10];
      sw_set = VECS[i][9:4];
      step();
      check("R2/R3/R4/R5 table req", 8'(vec_req), 8'(VECS[i][3]));
      if (VECS[i][3]) check("R2/R4/R5 table idx", 8'(vec_idx), 8'(VECS[i][2:0]));
      sw_clr = '1;
      step();
    end
    glb_en = 1'b1; src_en = '1; src_prio = '0;

    // R7 edge-mode external
    ext_pin[0] = 1'b1; step();
    check("R7 edge sets flag", 8'(irq_flags), 8'h01);
    check("R7 idx", 8'(vec_idx), 8'd0);
    vec_ack = 1'b1; step();
    check("R7 ack clears flag", 8'(irq_flags), 8'h00);
    step();
    check("R7 held pin no new edge", 8'(irq_flags), 8'h00);
    reti = 1'b1; ext_pin[0] = 1'b0; step();

    // R8 level-mode external
    ext_edge_mode[1] = 1'b0; ext_pin[1] = 1'b1; step();
    check("R8 level follows pin", 8'(irq_flags), 8'h04);
    check("R8 idx", 8'(vec_idx), 8'd2);
    vec_ack = 1'b1; step();
    check("R8 ack keeps flag", 8'(irq_flags), 8'h04);
    ext_pin[1] = 1'b0; step();
    check("R8 pin low drops flag", 8'(irq_flags), 8'h00);
    reti = 1'b1; step();
    sw_set[2] = 1'b1; step();
    check("R11 level flag ignores sw_set", 8'(irq_flags), 8'h00);
    ext_edge_mode[1] = 1'b1;

    // R9 timer
    tmr_ovf[1] = 1'b1; step();
    check("R9 ovf sets flag", 8'(irq_flags), 8'h08);
    check("R9 idx", 8'(vec_idx), 8'd3);
    vec_ack = 1'b1; step();
    check("R9 ack clears flag", 8'(irq_flags), 8'h00);
    reti = 1'b1; step();

    // R10 serial
    ser_rx_set = 1'b1; step();
    check("R10 rx sets flag", 8'(irq_flags), 8'h10);
    check("R10 idx", 8'(vec_idx), 8'd4);
    vec_ack = 1'b1; step();
    check("R10 ack keeps flag", 8'(irq_flags), 8'h10);
    check("R6 low waits in low routine", 8'(vec_req), 8'h0);
    reti = 1'b1; step();
    check("R12 reti reopens", 8'(vec_req), 8'h1);
    sw_clr[4] = 1'b1; step();
    check("R11 sw clear", 8'(irq_flags), 8'h00);

    // R6 / R12 nesting
    src_prio = 5'b01000;
    sw_set[1] = 1'b1; step();
    vec_ack = 1'b1; step();
    ser_tx_set = 1'b1; step();
    check("R6 low blocked by low routine", 8'(vec_req), 8'h0);
    sw_set[3] = 1'b1; step();
    check("R6 high preempts req", 8'(vec_req), 8'h1);
    check("R6 high preempts idx", 8'(vec_idx), 8'd3);
    check("R5 level reported", 8'(vec_hi), 8'h1);
    vec_ack = 1'b1; step();
    src_prio = 5'b01010; sw_set[1] = 1'b1; step();
    check("R6 same level waits", 8'(vec_req), 8'h0);
    reti = 1'b1; step();
    check("R12 high ends first req", 8'(vec_req), 8'h1);
    check("R12 high ends first idx", 8'(vec_idx), 8'd1);
    vec_ack = 1'b1; step();
    reti = 1'b1; step();
    check("R12 low still active", 8'(vec_req), 8'h0);
    reti = 1'b1; step();
    check("R12 low ended req", 8'(vec_req), 8'h1);
    check("R12 low ended idx", 8'(vec_idx), 8'd4);
    sw_clr = '1; src_prio = '0; step();

    // R12 ack with reti ignored
    sw_set[1] = 1'b1; step();
    vec_ack = 1'b1; reti = 1'b1; step();
    check("R12 ack during reti ignored flag", 8'(irq_flags), 8'h02);
    check("R12 ack during reti no routine", 8'(vec_req), 8'h1);

    // R11 set wins over clear
    sw_set[3] = 1'b1; sw_clr[3] = 1'b1; step();
    check("R11 set beats clear", 8'(irq_flags), 8'h0A);
    sw_clr = '1; step();
    check("R11 clear all", 8'(irq_flags), 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule